// File: doc/BRIEF.md
# Threshold-Driven Audio Sample FIFO

This block is a word-organized buffer placed between a DMA port and a serial audio shifter. It can serve either transfer direction. On the transmit path the DMA engine fills it and the shifter drains it. On the receive path the shifter fills it and the DMA engine drains it. Capacity is counted in words. A 16-bit word therefore uses one location, just as a 32-bit word does.

The block does not request DMA service word by word. It raises one request for a whole block of words. The block size is a programmable threshold. Once a request is raised, it stays high until that many words have crossed the DMA side of the buffer. An element mode sets the block size to a single word. The live occupancy is exported. Software divides it by the channel count to get the buffering latency in samples. Overflow and underflow are caught in sticky flags.

Top module: `thr_audio_fifo`

## Requirements
- R1: After reset, fill level is 0, the request is low, both flags are low and read data is 0.
- R2: Words are read out in the order they were accepted. Read data is registered and appears the cycle after the read strobe. The fill level rises by one for each accepted write and falls by one for each accepted read.
- R3: With `word32` low, bits above the lower half of each written word are stored as zero. With `word32` high, the full word is stored.
- R4: A write while the buffer holds DEPTH words is dropped, and the level stays at DEPTH. It sets `ovf_flag`, which stays set until reset. This holds even when a read happens in the same cycle.
- R5: A read while the buffer is empty returns 0 and leaves the level at 0. It sets `unf_flag`, which stays set until reset.
- R6: With `dir_tx` high (transmit: DMA writes), an idle block raises `dma_req` one cycle after the free space (DEPTH minus level) is at least the effective threshold.
- R7: With `dir_tx` low (receive: DMA reads), an idle block raises `dma_req` one cycle after the level is at least the effective threshold.
- R8: Once raised, `dma_req` stays high until the effective threshold number of accepted DMA-side transfers has occurred. It is low the cycle after the last of them, and the condition is evaluated again from that cycle onward.
- R9: With `elem_mode` high, the effective threshold is 1 whatever `thr_words` holds.
- R10: When `elem_mode` is low, a `thr_words` value of 0 acts as 1, and a value above THR_MAX acts as THR_MAX.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_tx | input | 1 | 1 = transmit buffer (DMA writes), 0 = receive buffer (DMA reads) |
| elem_mode | input | 1 | 1 = one request per word |
| word32 | input | 1 | 1 = full-width words, 0 = lower half only |
| thr_words | input | CNT_W | Programmed block threshold in words |
| wr_en | input | 1 | Write strobe |
| wr_data | input | WIDTH | Write word |
| rd_en | input | 1 | Read strobe |
| rd_data | output | WIDTH | Registered read word (0 on underflow) |
| dma_req | output | 1 | Block DMA request |
| fill_level | output | CNT_W | Occupied locations |
| ovf_flag | output | 1 | Sticky overflow |
| unf_flag | output | 1 | Sticky underflow |

## Verification
The tests use interleaved writes and reads, including simultaneous ones, to check ordering and level tracking. One pattern writes past full and then reads past empty. It shows that the dropped word really is absent and that the zero return comes from the empty case. The request tests run the transmit and receive directions with thresholds that land just before and just after the last transfer of a block. This separates a free-space compare from an occupancy compare, and a held request from a per-word one. Thresholds of 0, 1 in element mode, and one above the maximum confirm each clamp. With the above-maximum threshold the request ends one word earlier than an unclamped value would allow.

// File: rtl/thr_audio_fifo_pkg.sv
package thr_audio_fifo_pkg;
  typedef enum logic {
    REQ_IDLE  = 1'b0,
    REQ_BURST = 1'b1
  } req_state_e;
endpackage

// File: rtl/thr_audio_fifo_store.sv
module thr_audio_fifo_store #(
  parameter int DEPTH = 128,
  parameter int WIDTH = 32,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/thr_audio_fifo_ctrl.sv
module thr_audio_fifo_ctrl #(
  parameter int DEPTH = 128,
  parameter int WIDTH = 32,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             word32,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  input  logic [WIDTH-1:0] mem_q,
  output logic             mem_we,
  output logic [AW-1:0]    mem_waddr,
  output logic [WIDTH-1:0] mem_wdata,
  output logic [AW-1:0]    mem_raddr,
  output logic [WIDTH-1:0] rd_data,
  output logic [CNT_W-1:0] level,
  output logic             wr_acc,
  output logic             rd_acc,
  output logic             ovf_flag,
  output logic             unf_flag
);
  localparam logic [CNT_W-1:0] DEPTH_C  = CNT_W'(DEPTH);
  localparam logic [AW-1:0]    LAST_PTR = AW'(DEPTH - 1);
  localparam int               HALF_W   = WIDTH / 2;
  localparam logic [WIDTH-1:0] LOW_MASK = {{(WIDTH - HALF_W){1'b0}}, {HALF_W{1'b1}}};

  logic [AW-1:0]    wp_q, wp_d, rp_q, rp_d;
  logic [CNT_W-1:0] lvl_q, lvl_d;
  logic             ovf_q, ovf_d, unf_q, unf_d;
  logic [WIDTH-1:0] rdat_q, rdat_d;
  logic             full, empty;

  assign full   = (lvl_q == DEPTH_C);
  assign empty  = (lvl_q == '0);
  assign wr_acc = wr_en && !full;
  assign rd_acc = rd_en && !empty;

  assign mem_we    = wr_acc;
  assign mem_waddr = wp_q;
  assign mem_raddr = rp_q;
  assign mem_wdata = word32 ? wr_data : (wr_data & LOW_MASK);

  always_comb begin
    wp_d   = wp_q;
    rp_d   = rp_q;
    lvl_d  = lvl_q;
    ovf_d  = ovf_q | (wr_en & full);
    unf_d  = unf_q | (rd_en & empty);
    rdat_d = rdat_q;
    if (wr_acc) wp_d = (wp_q == LAST_PTR) ? '0 : wp_q + AW'(1);
    if (rd_acc) rp_d = (rp_q == LAST_PTR) ? '0 : rp_q + AW'(1);
    case ({wr_acc, rd_acc})
      2'b10:   lvl_d = lvl_q + CNT_W'(1);
      2'b01:   lvl_d = lvl_q - CNT_W'(1);
      default: lvl_d = lvl_q;
    endcase
    if (rd_en) rdat_d = rd_acc ? mem_q : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      lvl_q <= '0;
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      lvl_q <= lvl_d;
      ovf_q <= ovf_d;
      unf_q <= unf_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdat_q <= '0;
    else if (rd_en) rdat_q <= rdat_d;
  end

  assign rd_data  = rdat_q;
  assign level    = lvl_q;
  assign ovf_flag = ovf_q;
  assign unf_flag = unf_q;

  // R2: the level never exceeds the capacity
  a_r2_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    level <= DEPTH_C);

  // R2: one accepted write alone raises the level by one
  a_r2_level_inc: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !full && !rd_en) |=> (level == $past(level) + CNT_W'(1)));

  // R4: a write at full is dropped and flagged
  a_r4_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && full && !rd_en) |=> (level == DEPTH_C) && ovf_flag);

  // R4: overflow is sticky
  a_r4_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag |=> ovf_flag);

  // R5: reading empty returns zero and flags underflow
  a_r5_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && empty && !wr_en) |=> (rd_data == '0) && unf_flag && (level == '0));

  // R5: underflow is sticky
  a_r5_unf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    unf_flag |=> unf_flag);
endmodule

// File: rtl/thr_audio_fifo_req.sv
module thr_audio_fifo_req
  import thr_audio_fifo_pkg::*;
#(
  parameter int DEPTH   = 128,
  parameter int THR_MAX = 128,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dir_tx,
  input  logic             elem_mode,
  input  logic [CNT_W-1:0] thr_words,
  input  logic [CNT_W-1:0] level,
  input  logic             wr_acc,
  input  logic             rd_acc,
  output logic             dma_req
);
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] TMAX_C  = CNT_W'(THR_MAX);
  localparam logic [CNT_W-1:0] ONE_C   = CNT_W'(1);

  req_state_e       st_q, st_d;
  logic [CNT_W-1:0] left_q, left_d;
  logic [CNT_W-1:0] eff_thr, free_words;
  logic             ready, moved;

  always_comb begin
    if (elem_mode)                eff_thr = ONE_C;
    else if (thr_words == '0)     eff_thr = ONE_C;
    else if (thr_words > TMAX_C)  eff_thr = TMAX_C;
    else                          eff_thr = thr_words;
  end

  assign free_words = DEPTH_C - level;
  assign ready      = dir_tx ? (free_words >= eff_thr) : (level >= eff_thr);
  assign moved      = dir_tx ? wr_acc : rd_acc;

  always_comb begin
    st_d   = st_q;
    left_d = left_q;
    case (st_q)
      REQ_IDLE: begin
        if (ready) begin
          st_d   = REQ_BURST;
          left_d = eff_thr;
        end
      end
      REQ_BURST: begin
        if (moved) begin
          if (left_q == ONE_C) begin
            st_d   = REQ_IDLE;
            left_d = '0;
          end else begin
            left_d = left_q - ONE_C;
          end
        end
      end
      default: begin
        st_d   = REQ_IDLE;
        left_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= REQ_IDLE;
      left_q <= '0;
    end else begin
      st_q   <= st_d;
      left_q <= left_d;
    end
  end

  assign dma_req = (st_q == REQ_BURST);

  // R8: request held while the block is unfinished
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req && !moved) |=> dma_req);

  // R8: request drops after the last word of the block
  a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req && moved && left_q == ONE_C) |=> !dma_req);

  // R10: a started block length is always within 1..THR_MAX
  a_r10_block_len: assert property (@(posedge clk) disable iff (!rst_n)
    (!dma_req && ready) |=> (left_q >= ONE_C) && (left_q <= TMAX_C));

  // R9: element mode starts single-word blocks
  a_r9_elem_len: assert property (@(posedge clk) disable iff (!rst_n)
    (!dma_req && ready && elem_mode) |=> (left_q == ONE_C));
endmodule

// File: rtl/thr_audio_fifo.sv
module thr_audio_fifo #(
  parameter int DEPTH   = 128,
  parameter int WIDTH   = 32,
  parameter int THR_MAX = DEPTH,
  localparam int AW     = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dir_tx,
  input  logic             elem_mode,
  input  logic             word32,
  input  logic [CNT_W-1:0] thr_words,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic             dma_req,
  output logic [CNT_W-1:0] fill_level,
  output logic             ovf_flag,
  output logic             unf_flag
);
  logic             mem_we;
  logic [AW-1:0]    mem_waddr, mem_raddr;
  logic [WIDTH-1:0] mem_wdata, mem_q;
  logic             wr_acc, rd_acc;
  logic [CNT_W-1:0] level;

  thr_audio_fifo_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (mem_wdata),
    .raddr (mem_raddr),
    .rdata (mem_q)
  );

  thr_audio_fifo_ctrl #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .word32    (word32),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .rd_en     (rd_en),
    .mem_q     (mem_q),
    .mem_we    (mem_we),
    .mem_waddr (mem_waddr),
    .mem_wdata (mem_wdata),
    .mem_raddr (mem_raddr),
    .rd_data   (rd_data),
    .level     (level),
    .wr_acc    (wr_acc),
    .rd_acc    (rd_acc),
    .ovf_flag  (ovf_flag),
    .unf_flag  (unf_flag)
  );

  thr_audio_fifo_req #(.DEPTH(DEPTH), .THR_MAX(THR_MAX)) u_req (
    .clk       (clk),
    .rst_n     (rst_n),
    .dir_tx    (dir_tx),
    .elem_mode (elem_mode),
    .thr_words (thr_words),
    .level     (level),
    .wr_acc    (wr_acc),
    .rd_acc    (rd_acc),
    .dma_req   (dma_req)
  );

  assign fill_level = level;

  // R1: nothing is pending right after reset
  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (fill_level == '0) && !ovf_flag && !unf_flag);
endmodule

// File: tb/thr_audio_fifo_test.sv
module thr_audio_fifo_test;
  localparam int DEPTH = 8;
  localparam int WIDTH = 32;
  localparam int TMAX  = 6;
  localparam int CW    = $clog2(DEPTH + 1);

  typedef struct packed {
    logic        w32;
    logic        wr;
    logic        rd;
    logic [31:0] din;
    logic [3:0]  lvl;
    logic [31:0] dout;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b1, 1'b0, 32'h0000_00A1, 4'd1, 32'h0},
    '{1'b1, 1'b1, 1'b0, 32'h0000_00A2, 4'd2, 32'h0},
    '{1'b1, 1'b1, 1'b0, 32'h1234_56A3, 4'd3, 32'h0},
    '{1'b1, 1'b0, 1'b1, 32'h0,         4'd2, 32'h0000_00A1},
    '{1'b1, 1'b1, 1'b1, 32'hCAFE_00A4, 4'd2, 32'h0000_00A2},
    '{1'b1, 1'b0, 1'b1, 32'h0,         4'd1, 32'h1234_56A3},
    '{1'b1, 1'b0, 1'b1, 32'h0,         4'd0, 32'hCAFE_00A4},
    '{1'b0, 1'b1, 1'b0, 32'hDEAD_BEEF, 4'd1, 32'h0},
    '{1'b1, 1'b0, 1'b1, 32'h0,         4'd0, 32'h0000_BEEF}
  };

  logic             clk = 1'b0;
  logic             rst_n;
  logic             dir_tx, elem_mode, word32;
  logic [CW-1:0]    thr_words;
  logic             wr_en, rd_en;
  logic [WIDTH-1:0] wr_data, rd_data;
  logic             dma_req, ovf_flag, unf_flag;
  logic [CW-1:0]    fill_level;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  thr_audio_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH), .THR_MAX(TMAX)) uut (
    .clk(clk), .rst_n(rst_n), .dir_tx(dir_tx), .elem_mode(elem_mode),
    .word32(word32), .thr_words(thr_words), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .dma_req(dma_req),
    .fill_level(fill_level), .ovf_flag(ovf_flag), .unf_flag(unf_flag)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic do_reset(input logic tx, input logic el, input logic [CW-1:0] thr);
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; wr_data = '0;
    dir_tx = tx; elem_mode = el; thr_words = thr; word32 = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic cyc(input logic w, input logic r, input logic [31:0] d);
    @(negedge clk);
    wr_en = w; rd_en = r; wr_data = d;
    @(posedge clk);
    #1;
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  initial begin
    do_reset(1'b1, 1'b0, CW'(6));
    chk("R1 level", 32'(fill_level), 0);
    chk("R1 req", 32'(dma_req), 0);
    chk("R1 ovf", 32'(ovf_flag), 0);
    chk("R1 unf", 32'(unf_flag), 0);
    chk("R1 rdata", rd_data, 0);

    // R2/R3 table of interleaved traffic and word widths
    for (int i = 0; i < NV; i++) begin
      word32 = VECS[i].w32;
      cyc(VECS[i].wr, VECS[i].rd, VECS[i].din);
      chk($sformatf("R2 level vec%0d", i), 32'(fill_level), 32'(VECS[i].lvl));
      if (VECS[i].rd)
        chk($sformatf("R2/R3 data vec%0d", i), rd_data, VECS[i].dout);
    end
    word32 = 1'b1;

    // R4 overflow then R5 underflow
    do_reset(1'b1, 1'b0, CW'(6));
    for (int i = 0; i < DEPTH + 1; i++) cyc(1'b1, 1'b0, 32'(100 + i));
    chk("R4 level at full", 32'(fill_level), DEPTH);
    chk("R4 ovf set", 32'(ovf_flag), 1);
    cyc(1'b1, 1'b1, 32'h77);
    chk("R4 write with read at full dropped", 32'(fill_level), DEPTH - 1);
    chk("R4 data order", rd_data, 100);
    for (int i = 1; i < DEPTH; i++) begin
      cyc(1'b0, 1'b1, 32'h0);
      chk("R4 no dropped word stored", rd_data, 32'(100 + i));
    end
    chk("R5 no underflow yet", 32'(unf_flag), 0);
    cyc(1'b0, 1'b1, 32'h0);
    chk("R5 empty read zero", rd_data, 0);
    chk("R5 unf set", 32'(unf_flag), 1);
    chk("R5 level stays 0", 32'(fill_level), 0);
    cyc(1'b1, 1'b0, 32'h5);
    chk("R4 ovf sticky", 32'(ovf_flag), 1);
    chk("R5 unf sticky", 32'(unf_flag), 1);

    // R6/R8 transmit: threshold 4 on free space
    do_reset(1'b1, 1'b0, CW'(4));
    cyc(1'b0, 1'b0, 32'h0);
    chk("R6 tx req on free space", 32'(dma_req), 1);
    for (int i = 0; i < 3; i++) cyc(1'b1, 1'b0, 32'(i));
    chk("R8 req held mid block", 32'(dma_req), 1);
    cyc(1'b1, 1'b0, 32'h3);
    chk("R8 req drops after block", 32'(dma_req), 0);
    cyc(1'b0, 1'b0, 32'h0);
    chk("R6 tx req again with 4 free", 32'(dma_req), 1);
    for (int i = 0; i < 4; i++) cyc(1'b1, 1'b0, 32'(i));
    chk("R8 req drops at full", 32'(dma_req), 0);
    cyc(1'b0, 1'b0, 32'h0);
    chk("R6 no tx req without space", 32'(dma_req), 0);

    // R7/R8 receive: threshold 3 on occupancy
    do_reset(1'b0, 1'b0, CW'(3));
    for (int i = 0; i < 3; i++) cyc(1'b1, 1'b0, 32'(i));
    chk("R7 rx req not before level seen", 32'(dma_req), 0);
    cyc(1'b0, 1'b0, 32'h0);
    chk("R7 rx req on occupancy", 32'(dma_req), 1);
    cyc(1'b0, 1'b1, 32'h0);
    cyc(1'b0, 1'b1, 32'h0);
    chk("R8 rx req held", 32'(dma_req), 1);
    cyc(1'b0, 1'b1, 32'h0);
    chk("R8 rx req released", 32'(dma_req), 0);

    // R9 element mode ignores threshold 5
    do_reset(1'b0, 1'b1, CW'(5));
    cyc(1'b1, 1'b0, 32'h9);
    cyc(1'b0, 1'b0, 32'h0);
    chk("R9 elem req per word", 32'(dma_req), 1);
    cyc(1'b0, 1'b1, 32'h0);
    chk("R9 elem req drops after one", 32'(dma_req), 0);

    // R10 clamp of zero
    do_reset(1'b0, 1'b0, CW'(0));
    cyc(1'b0, 1'b0, 32'h0);
    chk("R10 zero threshold no req when empty", 32'(dma_req), 0);
    cyc(1'b1, 1'b0, 32'h1);
    cyc(1'b0, 1'b0, 32'h0);
    chk("R10 zero threshold acts as 1", 32'(dma_req), 1);

    // R10 clamp above maximum: 7 acts as 6
    do_reset(1'b1, 1'b0, CW'(7));
    cyc(1'b0, 1'b0, 32'h0);
    chk("R10 high threshold req", 32'(dma_req), 1);
    for (int i = 0; i < 5; i++) cyc(1'b1, 1'b0, 32'(i));
    chk("R10 held through 5", 32'(dma_req), 1);
    cyc(1'b1, 1'b0, 32'h5);
    chk("R10 block clamped to 6", 32'(dma_req), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule